// File: doc/BRIEF.md
# Card Window Address Decoder

This block sits between a host bus and a two-slot card interface. It holds eight programmable windows, each described by a base register and an option register. Every host request address is compared against all eight windows at once. When a window claims the address, the block reports which window won, which slot it targets, the address space (common memory, attribute memory or I/O), whether the card port is 16 bits wide, and the three access timing fields stored in that window. The timing fields are handed to a separate strobe generator, which is outside this block.

A window covers a power-of-two region whose size comes from a 5-bit size code. The code is not binary: its values follow a scrambled order, and five of them are reserved. Address bits below the decoded size are ignored in both the request and the base register. A write that lands in a write-protected window is not forwarded. Instead, a violation pulse is raised.

Software programs the windows through a small register port. That port has a synchronous write and a registered read. Request results appear one clock after the request.

Top module: `cwd_decoder`

## Requirements
- R1: The register port addresses sixteen 32-bit registers. `cfg_addr[3:1]` picks the window and `cfg_addr[0]` picks base (0) or option (1). A write with `cfg_wr_en` takes effect at the next clock edge. `cfg_rdata` shows the register at `cfg_addr` one clock after the address is presented.
- R2: A window can only hit when option bit 0 (enable) is 1 and its size code is valid. A window whose option register is zero never hits, and neither does a window with a reserved code (16, 17, 18, 19, 22).
- R3: The size code sits in option bits 31:27 and maps to these window sizes in bytes:
  - codes 0 to 15: 1, 2, 8, 4, 128, 64, 16, 32, 32K, 16K, 4K, 8K, 256, 512, 2K, 1K
  - codes 20, 21, 23: 16M, 32M, 64M
  - codes 24 to 31: 64K, 128K, 512K, 256K, 8M, 4M, 1M, 2M
- R4: A valid window hits when the request address and the base register agree on every bit at or above log2(size). Bits of the base below that position are ignored.
- R5: When several windows hit, the lowest-numbered one wins. `hit_onehot` has exactly the winner's bit set, and `hit_index` holds the winner's number.
- R6: On a hit, the winner's option fields are reported:
  - slot from bit 2
  - space from bits 4:3 (00 common, 10 attribute, 11 I/O)
  - 16-bit port from bit 6
  - hold from bits 19:16
  - setup from bits 15:12
  - strobe from bits 11:7
- R7: Option bit 1 write-protects a window. A write request won by such a window raises `wp_violation` for one cycle and leaves `fwd_valid` low. A read request to the same window is forwarded.
- R8: A request that no window claims raises `miss`. On a miss, `hit_valid`, `fwd_valid`, `wp_violation`, `hit_onehot`, `hit_index` and all attribute outputs are zero.
- R9: All request results are registered and appear exactly one clock after the cycle in which `req_valid` was high. In a cycle with no prior request, `hit_valid`, `miss`, `fwd_valid` and `wp_violation` are low.
- R10: Synchronous reset clears all sixteen registers and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select: window in bits 3:1, base/option in bit 0 |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Host request address |
| hit_valid | output | 1 | A window claimed the previous request |
| miss | output | 1 | No window claimed the previous request |
| hit_onehot | output | 8 | One-hot winner |
| hit_index | output | 3 | Winner number |
| hit_slot | output | 1 | Target slot (0 = A, 1 = B) |
| hit_space | output | 2 | Address space code |
| hit_wide | output | 1 | 16-bit card port |
| hit_hold | output | 4 | Hold time field |
| hit_setup | output | 4 | Setup time field |
| hit_strobe | output | 5 | Strobe length field |
| fwd_valid | output | 1 | Access may proceed to the card |
| wp_violation | output | 1 | Write blocked by write protection |

## Verification
The bench sweeps all 32 size codes on one window. It probes the last byte inside each region and the first byte past it. A wrong entry in the scrambled size table therefore shows up as a hit beyond the region or as a miss inside it. Overlapping windows check that the lowest number wins; a reversed priority encoder would report the larger window's neighbour. Windows that are disabled, zeroed, or given a reserved code must all miss; a decoder that ignored the enable bit or the reserved codes would claim those addresses. Writes and reads to a write-protected window must separate cleanly into a blocked pulse and a forwarded access, and a base register with stray low bits must still match its whole aligned region.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int CWD_NWIN   = 8;
    localparam int CWD_AW     = 32;
    localparam int CWD_DW     = 32;

    // Address space field values (option bits 4:3)
    typedef enum logic [1:0] {
        SPC_COMMON = 2'b00,
        SPC_RSVD   = 2'b01,
        SPC_ATTR   = 2'b10,
        SPC_IO     = 2'b11
    } space_e;

    // Decoded window size
    typedef struct packed {
        logic       ok;
        logic [4:0] lg2;
    } size_t;

    // Attributes reported on a hit
    typedef struct packed {
        logic       slot;
        space_e     space;
        logic       wide;
        logic [3:0] hold;
        logic [3:0] setup;
        logic [4:0] strobe;
        logic       wprot;
    } attr_t;

    // Size code to log2(bytes); reserved codes return ok = 0
    function automatic size_t decode_size(input logic [4:0] code);
        size_t s;
        s.ok  = 1'b1;
        s.lg2 = 5'd0;
        case (code)
            5'd0:  s.lg2 = 5'd0;
            5'd1:  s.lg2 = 5'd1;
            5'd2:  s.lg2 = 5'd3;
            5'd3:  s.lg2 = 5'd2;
            5'd4:  s.lg2 = 5'd7;
            5'd5:  s.lg2 = 5'd6;
            5'd6:  s.lg2 = 5'd4;
            5'd7:  s.lg2 = 5'd5;
            5'd8:  s.lg2 = 5'd15;
            5'd9:  s.lg2 = 5'd14;
            5'd10: s.lg2 = 5'd12;
            5'd11: s.lg2 = 5'd13;
            5'd12: s.lg2 = 5'd8;
            5'd13: s.lg2 = 5'd9;
            5'd14: s.lg2 = 5'd11;
            5'd15: s.lg2 = 5'd10;
            5'd20: s.lg2 = 5'd24;
            5'd21: s.lg2 = 5'd25;
            5'd23: s.lg2 = 5'd26;
            5'd24: s.lg2 = 5'd16;
            5'd25: s.lg2 = 5'd17;
            5'd26: s.lg2 = 5'd19;
            5'd27: s.lg2 = 5'd18;
            5'd28: s.lg2 = 5'd23;
            5'd29: s.lg2 = 5'd22;
            5'd30: s.lg2 = 5'd20;
            5'd31: s.lg2 = 5'd21;
            default: s.ok = 1'b0;
        endcase
        return s;
    endfunction

    // Pull reported attributes out of an option word
    function automatic attr_t opt_to_attr(input logic [31:0] opt);
        attr_t a;
        a.slot   = opt[2];
        a.space  = space_e'(opt[4:3]);
        a.wide   = opt[6];
        a.hold   = opt[19:16];
        a.setup  = opt[15:12];
        a.strobe = opt[11:7];
        a.wprot  = opt[1];
        return a;
    endfunction

endpackage

// File: rtl/cwd_regbank.sv
module cwd_regbank #(
    parameter int NWIN = cwd_pkg::CWD_NWIN,
    parameter int DW   = cwd_pkg::CWD_DW,
    localparam int IDX_W = $clog2(NWIN),
    localparam int RA_W  = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [RA_W-1:0]            addr,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic [NWIN-1:0][DW-1:0]    base_q,
    output logic [NWIN-1:0][DW-1:0]    opt_q
);

    logic [IDX_W-1:0] win_sel;
    logic             is_opt;

    assign win_sel = addr[RA_W-1:1];
    assign is_opt  = addr[0];

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q[w] <= '0;
                    opt_q[w]  <= '0;
                end else if (wr_en && (win_sel == IDX_W'(w))) begin
                    if (is_opt) opt_q[w]  <= wdata;
                    else        base_q[w] <= wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= is_opt ? opt_q[win_sel] : base_q[win_sel];
    end

    // A written option word is visible the next cycle
    AST_OPT_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_opt) |=> (opt_q[$past(win_sel)] == $past(wdata))); // R1

endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match #(
    parameter int AW = cwd_pkg::CWD_AW
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic          enable,
    input  logic [4:0]    size_code,
    output logic          hit
);
    import cwd_pkg::*;

    size_t           sz;
    logic [AW-1:0]   keep_mask;
    logic [AW-1:0]   diff;

    always_comb begin
        sz        = decode_size(size_code);
        keep_mask = {AW{1'b1}} << sz.lg2;
        diff      = (addr ^ base) & keep_mask;
        hit       = enable && sz.ok && (diff == '0);
    end

endmodule

// File: rtl/cwd_prio_sel.sv
module cwd_prio_sel #(
    parameter int N = cwd_pkg::CWD_NWIN,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so the lowest requester is written last
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cwd_decoder.sv
module cwd_decoder #(
    parameter int NWIN = cwd_pkg::CWD_NWIN,
    parameter int AW   = cwd_pkg::CWD_AW,
    parameter int DW   = cwd_pkg::CWD_DW,
    localparam int IDX_W = $clog2(NWIN),
    localparam int RA_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [RA_W-1:0]   cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    output logic              hit_valid,
    output logic              miss,
    output logic [NWIN-1:0]   hit_onehot,
    output logic [IDX_W-1:0]  hit_index,
    output logic              hit_slot,
    output logic [1:0]        hit_space,
    output logic              hit_wide,
    output logic [3:0]        hit_hold,
    output logic [3:0]        hit_setup,
    output logic [4:0]        hit_strobe,
    output logic              fwd_valid,
    output logic              wp_violation
);
    import cwd_pkg::*;

    logic [NWIN-1:0][DW-1:0] base_q;
    logic [NWIN-1:0][DW-1:0] opt_q;
    logic [NWIN-1:0]         raw_hit;
    logic [NWIN-1:0]         grant;
    logic [IDX_W-1:0]        grant_idx;
    logic                    any_hit;
    logic [DW-1:0]           win_opt;
    attr_t                   win_attr;
    logic                    blocked;
    logic                    unused_opt_bits;

    cwd_regbank #(.NWIN(NWIN), .DW(DW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr_en),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .base_q (base_q),
        .opt_q  (opt_q)
    );

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_match
            cwd_win_match #(.AW(AW)) u_match (
                .addr      (req_addr),
                .base      (base_q[w][AW-1:0]),
                .enable    (opt_q[w][0]),
                .size_code (opt_q[w][31:27]),
                .hit       (raw_hit[w])
            );
        end
    endgenerate

    cwd_prio_sel #(.N(NWIN)) u_prio (
        .req   (raw_hit),
        .grant (grant),
        .idx   (grant_idx),
        .any   (any_hit)
    );

    assign win_opt         = opt_q[grant_idx];
    assign win_attr        = opt_to_attr(win_opt);
    assign blocked         = req_write && win_attr.wprot;
    assign unused_opt_bits = ^{win_opt[31:20], win_opt[5], win_opt[0]};

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            hit_valid    <= 1'b0;
            miss         <= 1'b0;
            hit_onehot   <= '0;
            hit_index    <= '0;
            hit_slot     <= 1'b0;
            hit_space    <= 2'b00;
            hit_wide     <= 1'b0;
            hit_hold     <= '0;
            hit_setup    <= '0;
            hit_strobe   <= '0;
            fwd_valid    <= 1'b0;
            wp_violation <= 1'b0;
        end else if (any_hit) begin
            hit_valid    <= 1'b1;
            miss         <= 1'b0;
            hit_onehot   <= grant;
            hit_index    <= grant_idx;
            hit_slot     <= win_attr.slot;
            hit_space    <= win_attr.space;
            hit_wide     <= win_attr.wide;
            hit_hold     <= win_attr.hold;
            hit_setup    <= win_attr.setup;
            hit_strobe   <= win_attr.strobe;
            fwd_valid    <= !blocked;
            wp_violation <= blocked;
        end else begin
            hit_valid    <= 1'b0;
            miss         <= 1'b1;
            hit_onehot   <= '0;
            hit_index    <= '0;
            hit_slot     <= 1'b0;
            hit_space    <= 2'b00;
            hit_wide     <= 1'b0;
            hit_hold     <= '0;
            hit_setup    <= '0;
            hit_strobe   <= '0;
            fwd_valid    <= 1'b0;
            wp_violation <= 1'b0;
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> ($countones(hit_onehot) == 1)); // R5
    AST_INDEX_AGREES: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> hit_onehot[hit_index]); // R5
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> ((raw_hit & (grant - 1'b1)) == '0)); // R5
    AST_WP_BLOCKS_FWD: assert property (@(posedge clk) disable iff (rst)
        wp_violation |-> (hit_valid && !fwd_valid)); // R7
    AST_WP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wp_violation |-> $past(req_write)); // R7
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        miss |-> (!hit_valid && !fwd_valid && hit_onehot == '0)); // R8
    AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (hit_valid || miss) |-> $past(req_valid)); // R9
    AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (hit_valid ^ miss)); // R9

endmodule

// File: tb/cwd_decoder_test.sv
module cwd_decoder_test;

    typedef struct packed {
        logic [7:0]  tag;
        logic        hit;
        logic [7:0]  onehot;
        logic [2:0]  idx;
        logic        slot;
        logic [1:0]  space;
        logic        wide;
        logic [3:0]  hold;
        logic [3:0]  setup;
        logic [4:0]  strobe;
        logic        fwd;
        logic        wpv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit_valid, miss, hit_slot, hit_wide, fwd_valid, wp_violation;
    logic [7:0]  hit_onehot;
    logic [2:0]  hit_index;
    logic [1:0]  hit_space;
    logic [3:0]  hit_hold, hit_setup;
    logic [4:0]  hit_strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] sh_base [8];
    logic [31:0] sh_opt  [8];
    exp_t        sb_q [$];

    always #2 clk = ~clk; // 250 MHz

    cwd_decoder uut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .hit_valid(hit_valid),
        .miss(miss), .hit_onehot(hit_onehot), .hit_index(hit_index),
        .hit_slot(hit_slot), .hit_space(hit_space), .hit_wide(hit_wide),
        .hit_hold(hit_hold), .hit_setup(hit_setup), .hit_strobe(hit_strobe),
        .fwd_valid(fwd_valid), .wp_violation(wp_violation)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Window size in bytes; zero for reserved codes (R3)
    function automatic logic [32:0] size_bytes(input logic [4:0] code);
        case (code)
            0: return 33'd1;          1: return 33'd2;
            2: return 33'd8;          3: return 33'd4;
            4: return 33'd128;        5: return 33'd64;
            6: return 33'd16;         7: return 33'd32;
            8: return 33'h8000;       9: return 33'h4000;
            10: return 33'h1000;      11: return 33'h2000;
            12: return 33'h100;       13: return 33'h200;
            14: return 33'h800;       15: return 33'h400;
            20: return 33'h100_0000;  21: return 33'h200_0000;
            23: return 33'h400_0000;  24: return 33'h1_0000;
            25: return 33'h2_0000;    26: return 33'h8_0000;
            27: return 33'h4_0000;    28: return 33'h80_0000;
            29: return 33'h40_0000;   30: return 33'h10_0000;
            31: return 33'h20_0000;
            default: return 33'd0;
        endcase
    endfunction

    function automatic logic [31:0] mk_opt(input logic [4:0] code, input logic [3:0] hold,
        input logic [3:0] setup, input logic [4:0] strobe, input logic wide,
        input logic [1:0] space, input logic slot, input logic wp, input logic en);
        return {code, 7'd0, hold, setup, strobe, wide, 1'b0, space, slot, wp, en};
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic wr, input logic [7:0] tag);
        exp_t e;
        e = '0;
        e.tag = tag;
        for (int w = 7; w >= 0; w--) begin
            logic [32:0] sz;
            logic [31:0] lowmask;
            sz = size_bytes(sh_opt[w][31:27]);
            lowmask = 32'(sz - 33'd1);
            if (sh_opt[w][0] && sz != 0 && ((a & ~lowmask) == (sh_base[w] & ~lowmask))) begin
                e.hit    = 1'b1;
                e.onehot = 8'(1 << w);
                e.idx    = 3'(w);
                e.slot   = sh_opt[w][2];
                e.space  = sh_opt[w][4:3];
                e.wide   = sh_opt[w][6];
                e.hold   = sh_opt[w][19:16];
                e.setup  = sh_opt[w][15:12];
                e.strobe = sh_opt[w][11:7];
                e.wpv    = wr && sh_opt[w][1];
                e.fwd    = !(wr && sh_opt[w][1]);
            end
        end
        return e;
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        if (a[0]) sh_opt[a[3:1]] = d; else sh_base[a[3:1]] = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read_check(input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_addr  = a;
        @(posedge clk);
        #1;
        check(cfg_rdata == exp, "R1 readback", 64'(cfg_rdata), 64'(exp));
    endtask

    // Driver: drive one request and push what it should produce
    task automatic send(input logic [31:0] a, input logic wr, input logic [7:0] tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        sb_q.push_back(model(a, wr, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Monitor: a request seen at an edge yields a result just after it (R9)
    always @(posedge clk) begin
        logic had;
        had = req_valid && !rst;
        #1;
        if (had) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9 queue empty", 64'(hit_valid), 64'd0);
            end else begin
                exp_t e;
                string r;
                e = sb_q.pop_front();
                r = $sformatf("R%0d", e.tag);
                check(hit_valid == e.hit && miss == !e.hit, {r, " hit/miss"}, 64'(hit_valid), 64'(e.hit));
                check(hit_onehot == e.onehot && hit_index == e.idx, {r, " winner"},
                      64'({hit_onehot, hit_index}), 64'({e.onehot, e.idx}));
                check({hit_slot, hit_space, hit_wide, hit_hold, hit_setup, hit_strobe} ==
                      {e.slot, e.space, e.wide, e.hold, e.setup, e.strobe}, {r, " attributes"},
                      64'({hit_slot, hit_space, hit_wide, hit_hold, hit_setup, hit_strobe}),
                      64'({e.slot, e.space, e.wide, e.hold, e.setup, e.strobe}));
                check(fwd_valid == e.fwd && wp_violation == e.wpv, {r, " fwd/wp"},
                      64'({fwd_valid, wp_violation}), 64'({e.fwd, e.wpv}));
            end
        end else if (!rst && !done) begin
            check(!hit_valid && !miss && !fwd_valid && !wp_violation, "R9 idle quiet",
                  64'({hit_valid, miss, fwd_valid, wp_violation}), 64'd0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 8; w++) begin
            sh_base[w] = '0;
            sh_opt[w]  = '0;
        end
        repeat (4) @(posedge clk);
        #1;
        // R10: outputs clear during reset
        check({hit_valid, miss, fwd_valid, wp_violation, hit_onehot, cfg_rdata} == '0,
              "R10 reset outputs", 64'({hit_valid, miss, fwd_valid, wp_violation, hit_onehot}), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        cfg_read_check(4'd7, 32'd0);   // R10 option of window 3 cleared
        cfg_read_check(4'd10, 32'd0);  // R10 base of window 5 cleared

        // R2: nothing programmed, every address misses
        send(32'h0000_0000, 1'b0, 8'd2);
        send(32'h1000_2010, 1'b1, 8'd8);
        idle();

        // Window setup
        cfg_write(4'd0, 32'h0000_0000);
        cfg_write(4'd1, mk_opt(5'd17, 4'd1, 4'd1, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1)); // reserved code
        cfg_write(4'd2, 32'h1000_0000);
        cfg_write(4'd3, mk_opt(5'd24, 4'd2, 4'd3, 5'd9, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));  // 64K common
        cfg_write(4'd4, 32'h3000_0000);
        cfg_write(4'd5, mk_opt(5'd24, 4'd0, 4'd0, 5'd0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0));  // disabled
        cfg_write(4'd6, 32'h1000_2000);
        cfg_write(4'd7, mk_opt(5'd10, 4'd5, 4'd6, 5'd17, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1)); // 4K attr slot B
        cfg_write(4'd8, 32'h2000_0103);
        cfg_write(4'd9, mk_opt(5'd2, 4'd7, 4'd8, 5'd3, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1));   // 8B IO
        cfg_write(4'd10, 32'h2000_0005);
        cfg_write(4'd11, mk_opt(5'd0, 4'd9, 4'd10, 5'd31, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1)); // 1B IO wp
        cfg_read_check(4'd7, mk_opt(5'd10, 4'd5, 4'd6, 5'd17, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1)); // R1
        cfg_read_check(4'd8, 32'h2000_0103); // R1

        send(32'h0000_0000, 1'b0, 8'd2);  // R2 reserved code never hits
        send(32'h3000_0010, 1'b0, 8'd2);  // R2 enable bit clear
        send(32'h1000_2010, 1'b0, 8'd5);  // R5 windows 1 and 3 overlap, 1 wins
        send(32'h1000_FFFF, 1'b1, 8'd4);  // R4 top byte of 64K
        send(32'h1001_0000, 1'b0, 8'd8);  // R8 just past
        send(32'h0FFF_FFFF, 1'b0, 8'd8);  // R8 just below
        send(32'h2000_0100, 1'b1, 8'd4);  // R4 base low bits ignored
        send(32'h2000_0107, 1'b0, 8'd6);  // R6 IO wide
        send(32'h2000_0108, 1'b0, 8'd8);  // R8
        send(32'h2000_0005, 1'b0, 8'd7);  // R7 read of protected window forwards
        send(32'h2000_0005, 1'b1, 8'd7);  // R7 write blocked
        send(32'h2000_0005, 1'b1, 8'd7);  // R7 back-to-back blocked
        send(32'h2000_0004, 1'b1, 8'd8);  // R8
        idle();

        // R2: clearing the option word of window 1 lets window 3 win
        cfg_write(4'd3, 32'h0000_0000);
        send(32'h1000_2010, 1'b0, 8'd6);  // R6 attribute space, slot B
        send(32'h1000_2FFF, 1'b1, 8'd6);
        send(32'h1000_3000, 1'b0, 8'd2);
        idle();

        // R3: sweep every size code on window 7
        cfg_write(4'd14, 32'h4000_0000);
        for (int c = 0; c < 32; c++) begin
            logic [32:0] sz;
            sz = size_bytes(5'(c));
            cfg_write(4'd15, mk_opt(5'(c), 4'(c), 4'(c + 3), 5'(c), 1'(c), 2'b00, 1'(c >> 1), 1'b0, 1'b1));
            if (sz != 0) begin
                send(32'h4000_0000 + 32'(sz) - 32'd1, 1'b0, 8'd3);
                send(32'h4000_0000 + 32'(sz), 1'b0, 8'd3);
            end else begin
                send(32'h4000_0000, 1'b0, 8'd3);
            end
            idle();
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule